// File: doc/BRIEF.md
# Tagged Boot Image Parser

This block walks a boot image held in a word-addressed ROM and uses it to fill a target memory. The image is a chain of blocks. Each block opens with two header words: the first carries a block kind, the number of the processor the block belongs to, and a word count; the second carries the destination address. Blocks meant for this processor either copy their payload from ROM or fill memory with zeros. Blocks meant for other processors are stepped over without any write.

A final block ends the walk. It replaces the low region of memory, which is where the loader itself sits. Its first four payload words are held back in staging registers. The remaining words are written to their places, and the staged words are written last. Only then does the block report completion with the entry address. A malformed block kind stops the walk and raises an error flag. A new start pulse clears that flag.

Top module: `boot_image_walker`

## Requirements
- R1: A pulse on `bootGo` while idle or halted on error starts a walk. The first header word is read from ROM word address 0x400.
- R2: In the first header word, bits 31:30 hold the kind, bits 29:27 the processor number and bits 15:0 the count. Bits 26:16 are ignored. The second header word is the destination address.
- R3: Kind 1 (copy) writes the `count` payload words that follow the header to destination, destination+1, and so on, in ROM order.
- R4: Kind 2 (zero fill) writes `count` zero words to consecutive destinations and reads no payload from ROM. The next header follows its two header words directly.
- R5: A block whose processor number differs from `localId` causes no write. The ROM pointer then skips ahead past the block: 2 words for kind 2, 2+count words for kind 1, and 2+256 words for kind 0.
- R6: A copy or zero-fill block with a count of zero is legal. It writes nothing, and parsing continues with the next header.
- R7: Kind 3, whatever its processor number, stops the walk without any further write and without `bootDone`. `bootError` is then held high until the next `bootGo`.
- R8: A kind-0 block for this processor consumes 256 payload words and ignores its destination and count. Words 4..255 are written in ascending order to addresses 4..255. After that, the first four words are written to addresses 0..3.
- R9: One cycle after the last staged write, `bootDone` is high for exactly one cycle with `startPc` equal to 0. The block then returns to idle.
- R10: After reset the block is idle with `memWe`, `bootDone` and `bootError` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bootGo | input | 1 | Start pulse |
| localId | input | 3 | Processor number of this device |
| romAddr | output | 16 | ROM word address |
| romData | input | 32 | ROM word, combinational from romAddr |
| memWe | output | 1 | Target memory write enable |
| memAddr | output | 32 | Target memory write address |
| memData | output | 32 | Target memory write data |
| bootDone | output | 1 | One-cycle completion pulse |
| startPc | output | 32 | Entry address, valid with bootDone |
| bootError | output | 1 | Malformed block seen, held until restart |

## Verification
The bench builds one image that mixes blocks for this processor with blocks for others, including a skipped final block. If the skip length for any kind were wrong, every later header would be misread and the writes would drift off the expected stream. Zero-count blocks and a zero-fill block directly followed by a header catch a design that writes once too often or consumes payload for zero fill. The final block is checked for its exact write order: a design that wrote the staged words first, or used the header destination, shows up as mismatched addresses. An image ending in a kind-3 word checks that writing halts, no completion pulse appears and the error flag persists until a restart.

// File: rtl/bootwalk_pkg.sv
package bootwalk_pkg;

  typedef enum logic [1:0] {
    BLK_FINAL = 2'd0,
    BLK_COPY  = 2'd1,
    BLK_ZERO  = 2'd2,
    BLK_BAD   = 2'd3
  } blkKind_e;

  typedef enum logic [2:0] {
    WR_NONE = 3'd0,
    WR_COPY = 3'd1,
    WR_ZERO = 3'd2,
    WR_BODY = 3'd3,
    WR_TAIL = 3'd4
  } wrSrc_e;

  // control -> datapath
  typedef struct packed {
    logic   ptrInit;
    logic   ptrStep;
    logic   ptrSkip;
    logic   tagLoad;
    logic   destLoad;
    logic   idxClr;
    logic   idxStep;
    logic   stageLoad;
    wrSrc_e wrSrc;
  } strobe_t;

  // datapath -> control
  typedef struct packed {
    blkKind_e blkKind;
    logic     idMatch;
    logic     countZero;
    logic     lastCount;
    logic     lastStage;
    logic     lastBody;
  } status_t;

endpackage

// File: rtl/bootwalk_datapath.sv
module bootwalk_datapath
  import bootwalk_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ROM_AW    = 16,
  parameter int MEM_AW    = 32,
  parameter int CNT_W     = 16,
  parameter int ID_W      = 3,
  parameter int ROM_BASE  = 'h400,
  parameter int STAGE_N   = 4,
  parameter int FINAL_LEN = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ID_W-1:0]   localId,
  input  logic [DATA_W-1:0] romData,
  output logic [ROM_AW-1:0] romAddr,
  output status_t           st,
  output logic              memWe,
  output logic [MEM_AW-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);

  localparam int KIND_HI = DATA_W - 1;
  localparam int KIND_LO = DATA_W - 2;
  localparam int ID_HI   = DATA_W - 3;
  localparam int ID_LO   = ID_HI - ID_W + 1;
  localparam int STG_W   = (STAGE_N > 1) ? $clog2(STAGE_N) : 1;
  localparam logic [CNT_W-1:0]  CNT_ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0]  STAGE_LAST = CNT_W'(STAGE_N - 1);
  localparam logic [CNT_W-1:0]  BODY_LAST  = CNT_W'(FINAL_LEN - 1);
  localparam logic [ROM_AW-1:0] FINAL_SKIP = ROM_AW'(FINAL_LEN);

  logic [ROM_AW-1:0] romPtr;
  blkKind_e          tagKind;
  logic [ID_W-1:0]   tagId;
  logic [CNT_W-1:0]  tagCount;
  logic [MEM_AW-1:0] destAddr;
  logic [CNT_W-1:0]  idx;
  logic [DATA_W-1:0] stage [STAGE_N];
  logic [ROM_AW-1:0] skipLen;

  assign romAddr = romPtr;

  always_comb begin
    case (tagKind)
      BLK_COPY:  skipLen = ROM_AW'(tagCount);
      BLK_FINAL: skipLen = FINAL_SKIP;
      default:   skipLen = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romPtr <= '0;
    end else if (stb.ptrInit) begin
      romPtr <= ROM_AW'(ROM_BASE);
    end else if (stb.ptrSkip) begin
      romPtr <= romPtr + skipLen;
    end else if (stb.ptrStep) begin
      romPtr <= romPtr + ROM_AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagKind  <= BLK_FINAL;
      tagId    <= '0;
      tagCount <= '0;
      destAddr <= '0;
    end else begin
      if (stb.tagLoad) begin
        tagKind  <= blkKind_e'(romData[KIND_HI:KIND_LO]);
        tagId    <= romData[ID_HI:ID_LO];
        tagCount <= romData[CNT_W-1:0];
      end
      if (stb.destLoad) destAddr <= romData[MEM_AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            idx <= '0;
    else if (stb.idxClr)  idx <= '0;
    else if (stb.idxStep) idx <= idx + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGE_N; i++) stage[i] <= '0;
    end else if (stb.stageLoad) begin
      stage[idx[STG_W-1:0]] <= romData;
    end
  end

  assign st.blkKind   = tagKind;
  assign st.idMatch   = (tagId == localId);
  assign st.countZero = (tagCount == '0);
  assign st.lastCount = (idx == tagCount - CNT_ONE);
  assign st.lastStage = (idx == STAGE_LAST);
  assign st.lastBody  = (idx == BODY_LAST);

  always_comb begin
    memWe   = 1'b1;
    memAddr = '0;
    memData = '0;
    case (stb.wrSrc)
      WR_COPY: begin
        memAddr = destAddr + MEM_AW'(idx);
        memData = romData;
      end
      WR_ZERO: begin
        memAddr = destAddr + MEM_AW'(idx);
      end
      WR_BODY: begin
        memAddr = MEM_AW'(idx);
        memData = romData;
      end
      WR_TAIL: begin
        memAddr = MEM_AW'(idx);
        memData = stage[idx[STG_W-1:0]];
      end
      default: memWe = 1'b0;
    endcase
  end

  // zero fill reads nothing from ROM
  assert_zero_no_rom_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrSrc == WR_ZERO) |=> (romPtr == $past(romPtr)));

  // each copied word consumes exactly one ROM word
  assert_copy_advance_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrSrc == WR_COPY) |=> (romPtr == $past(romPtr) + ROM_AW'(1)));

  assert_tail_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrSrc == WR_TAIL) |-> (memAddr < MEM_AW'(STAGE_N)));

  assert_body_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrSrc == WR_BODY) |-> (memAddr >= MEM_AW'(STAGE_N) && memAddr < MEM_AW'(FINAL_LEN)));

endmodule

// File: rtl/bootwalk_ctrl.sv
module bootwalk_ctrl
  import bootwalk_pkg::*;
#(
  parameter int MEM_AW   = 32,
  parameter int ENTRY_PC = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bootGo,
  input  status_t           st,
  output strobe_t           stb,
  output logic              bootDone,
  output logic              bootError,
  output logic [MEM_AW-1:0] startPc
);

  typedef enum logic [3:0] {
    S_IDLE, S_TAG0, S_TAG1, S_DISPATCH, S_COPY, S_ZERO,
    S_STAGE, S_BODY, S_TAIL, S_DONE, S_ERR
  } state_e;

  state_e state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt = state;
    stb = '0;
    case (state)
      S_IDLE, S_ERR: begin
        if (bootGo) begin
          stb.ptrInit = 1'b1;
          nxt = S_TAG0;
        end
      end
      S_TAG0: begin
        stb.tagLoad = 1'b1;
        stb.ptrStep = 1'b1;
        nxt = S_TAG1;
      end
      S_TAG1: begin
        stb.destLoad = 1'b1;
        stb.ptrStep  = 1'b1;
        stb.idxClr   = 1'b1;
        nxt = S_DISPATCH;
      end
      S_DISPATCH: begin
        if (st.blkKind == BLK_BAD) begin
          nxt = S_ERR;
        end else if (!st.idMatch) begin
          stb.ptrSkip = 1'b1;
          nxt = S_TAG0;
        end else begin
          case (st.blkKind)
            BLK_COPY: nxt = st.countZero ? S_TAG0 : S_COPY;
            BLK_ZERO: nxt = st.countZero ? S_TAG0 : S_ZERO;
            default:  nxt = S_STAGE;
          endcase
        end
      end
      S_COPY: begin
        stb.wrSrc   = WR_COPY;
        stb.ptrStep = 1'b1;
        stb.idxStep = 1'b1;
        if (st.lastCount) nxt = S_TAG0;
      end
      S_ZERO: begin
        stb.wrSrc   = WR_ZERO;
        stb.idxStep = 1'b1;
        if (st.lastCount) nxt = S_TAG0;
      end
      S_STAGE: begin
        stb.stageLoad = 1'b1;
        stb.ptrStep   = 1'b1;
        stb.idxStep   = 1'b1;
        if (st.lastStage) nxt = S_BODY;
      end
      S_BODY: begin
        stb.wrSrc   = WR_BODY;
        stb.ptrStep = 1'b1;
        if (st.lastBody) begin
          stb.idxClr = 1'b1;
          nxt = S_TAIL;
        end else begin
          stb.idxStep = 1'b1;
        end
      end
      S_TAIL: begin
        stb.wrSrc   = WR_TAIL;
        stb.idxStep = 1'b1;
        if (st.lastStage) nxt = S_DONE;
      end
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign bootDone  = (state == S_DONE);
  assign bootError = (state == S_ERR);
  assign startPc   = bootDone ? MEM_AW'(ENTRY_PC) : '0;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |=> !bootDone);

  assert_done_after_tail_R9: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |-> ($past(stb.wrSrc) == WR_TAIL));

  assert_error_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (bootError && !bootGo) |=> bootError);

  assert_error_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bootError) |-> ($past(st.blkKind) == BLK_BAD));

  assert_error_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    bootError |-> (stb.wrSrc == WR_NONE));

endmodule

// File: rtl/boot_image_walker.sv
module boot_image_walker
  import bootwalk_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ROM_AW    = 16,
  parameter int MEM_AW    = 32,
  parameter int CNT_W     = 16,
  parameter int ID_W      = 3,
  parameter int ROM_BASE  = 'h400,
  parameter int STAGE_N   = 4,
  parameter int FINAL_LEN = 256,
  parameter int ENTRY_PC  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bootGo,
  input  logic [ID_W-1:0]   localId,
  output logic [ROM_AW-1:0] romAddr,
  input  logic [DATA_W-1:0] romData,
  output logic              memWe,
  output logic [MEM_AW-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              bootDone,
  output logic [MEM_AW-1:0] startPc,
  output logic              bootError
);

  strobe_t stb;
  status_t st;

  bootwalk_ctrl #(
    .MEM_AW  (MEM_AW),
    .ENTRY_PC(ENTRY_PC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bootGo   (bootGo),
    .st       (st),
    .stb      (stb),
    .bootDone (bootDone),
    .bootError(bootError),
    .startPc  (startPc)
  );

  bootwalk_datapath #(
    .DATA_W   (DATA_W),
    .ROM_AW   (ROM_AW),
    .MEM_AW   (MEM_AW),
    .CNT_W    (CNT_W),
    .ID_W     (ID_W),
    .ROM_BASE (ROM_BASE),
    .STAGE_N  (STAGE_N),
    .FINAL_LEN(FINAL_LEN)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .localId(localId),
    .romData(romData),
    .romAddr(romAddr),
    .st     (st),
    .memWe  (memWe),
    .memAddr(memAddr),
    .memData(memData)
  );

endmodule

// File: tb/boot_image_walker_bench.sv
module boot_image_walker_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bootGo = 1'b0;
  logic [2:0]  localId = 3'd2;
  logic [15:0] romAddr;
  logic [31:0] romData;
  logic        memWe;
  logic [31:0] memAddr;
  logic [31:0] memData;
  logic        bootDone;
  logic [31:0] startPc;
  logic        bootError;

  logic [31:0] rom [0:4095];
  assign romData = rom[romAddr[11:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_image_walker u_boot_image_walker (
    .clk(clk), .rstN(rstN), .bootGo(bootGo), .localId(localId),
    .romAddr(romAddr), .romData(romData),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .bootDone(bootDone), .startPc(startPc), .bootError(bootError)
  );

  int nChecks = 0;
  int nFails  = 0;
  int wp;
  int doneCount = 0;
  logic prevDone = 1'b0;

  logic [31:0] expAddr [$];
  logic [31:0] expData [$];
  string       expReq  [$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // monitor: pops the scoreboard on every write, watches the done pulse
  always @(negedge clk) begin
    if (rstN) begin
      if (memWe) begin
        if (expAddr.size() == 0) begin
          check(1'b0, "R5", "unexpected write addr", memAddr, 32'h0);
        end else begin
          logic [31:0] ea, ed;
          string r;
          ea = expAddr.pop_front();
          ed = expData.pop_front();
          r  = expReq.pop_front();
          check(memAddr == ea, r, "write address", memAddr, ea);
          check(memData == ed, r, "write data", memData, ed);
        end
      end
      if (bootDone) begin
        doneCount++;
        check(startPc == 32'h0, "R9", "startPc at done", startPc, 32'h0);
        check(expAddr.size() == 0, "R8", "writes pending at done",
              32'(expAddr.size()), 32'h0);
        check(!prevDone, "R9", "done longer than one cycle", 32'(prevDone), 32'h0);
      end
      prevDone = bootDone;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R9", "watchdog expired", 32'h0, 32'h1);
    finishRun();
  end

  // ---------- image builder (driver) ----------
  function automatic logic [31:0] hdr(input int kind, input int id,
                                      input int cnt, input int rsv);
    logic [31:0] w;
    w = 32'h0;
    w[31:30] = kind[1:0];
    w[29:27] = id[2:0];
    w[26:16] = rsv[10:0];
    w[15:0]  = cnt[15:0];
    return w;
  endfunction

  task automatic clearRom();
    for (int i = 0; i < 4096; i++) rom[i] = 32'hFFFF_FFFF;
    wp = 'h400;
  endtask

  task automatic putW(input logic [31:0] w);
    rom[wp[11:0]] = w;
    wp++;
  endtask

  task automatic pushExp(input logic [31:0] a, input logic [31:0] d, input string r);
    expAddr.push_back(a);
    expData.push_back(d);
    expReq.push_back(r);
  endtask

  // R3 copy block
  task automatic addCopy(input int id, input int cnt, input logic [31:0] dest, input int rsv);
    putW(hdr(1, id, cnt, rsv));
    putW(dest);
    for (int i = 0; i < cnt; i++) begin
      logic [31:0] d;
      d = 32'hA500_0000 + 32'(wp * 7);
      putW(d);
      if (id == int'(localId)) pushExp(dest + 32'(i), d, "R3");
    end
  endtask

  // R4 zero-fill block: header only
  task automatic addZero(input int id, input int cnt, input logic [31:0] dest);
    putW(hdr(2, id, cnt, 0));
    putW(dest);
    if (id == int'(localId))
      for (int i = 0; i < cnt; i++) pushExp(dest + 32'(i), 32'h0, "R4");
  endtask

  // R8 final block: 256 payload words
  task automatic addFinal(input int id, input int cnt, input logic [31:0] dest);
    logic [31:0] first [4];
    putW(hdr(0, id, cnt, 0));
    putW(dest);
    for (int i = 0; i < 256; i++) begin
      logic [31:0] d;
      d = 32'hF1A0_0000 + 32'(i * 3 + id);
      putW(d);
      if (i < 4) first[i] = d;
      else if (id == int'(localId)) pushExp(32'(i), d, "R8");
    end
    if (id == int'(localId))
      for (int i = 0; i < 4; i++) pushExp(32'(i), first[i], "R8");
  endtask

  task automatic pulseGo();
    @(negedge clk);
    bootGo = 1'b1;
    @(negedge clk);
    bootGo = 1'b0;
  endtask

  task automatic waitEnd();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (bootDone || bootError) break;
    end
  endtask

  initial begin
    clearRom();
    repeat (3) @(negedge clk);
    check(memWe == 1'b0, "R10", "memWe in reset", 32'(memWe), 32'h0);
    check(bootDone == 1'b0, "R10", "bootDone in reset", 32'(bootDone), 32'h0);
    check(bootError == 1'b0, "R10", "bootError in reset", 32'(bootError), 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(memWe == 1'b0, "R10", "memWe idle after reset", 32'(memWe), 32'h0);

    // ---- image 1: mixed blocks, localId = 2 ----
    localId = 3'd2;
    addCopy(2, 3, 32'h0000_1000, 'h5A5);  // R2 reserved bits set
    addCopy(5, 4, 32'h0000_9000, 0);      // R5 skip 2+4
    addZero(2, 5, 32'h0000_2000);         // R4
    addZero(7, 9, 32'h0000_9100);         // R5 skip 2
    addCopy(2, 0, 32'h0000_3000, 0);      // R6
    addZero(2, 0, 32'h0000_3100);         // R6
    addFinal(6, 12, 32'h0000_9200);       // R5 skip 2+256
    addCopy(2, 2, 32'h0000_4000, 0);      // R3 after skipped final
    addFinal(2, 7, 32'h0000_7777);        // R8 dest and count ignored
    @(negedge clk);
    bootGo = 1'b1;
    @(negedge clk);
    bootGo = 1'b0;
    check(romAddr == 16'h0400, "R1", "first header address", 32'(romAddr), 32'h400);
    waitEnd();
    repeat (3) @(negedge clk);
    check(doneCount == 1, "R9", "done pulses image 1", 32'(doneCount), 32'h1);
    check(bootError == 1'b0, "R7", "no error image 1", 32'(bootError), 32'h0);
    check(expAddr.size() == 0, "R5", "writes left image 1", 32'(expAddr.size()), 32'h0);

    // ---- image 2: malformed kind stops the walk ----
    clearRom();
    addCopy(2, 2, 32'h0000_5000, 0);
    putW(hdr(3, 1, 4, 0));                // R7 other id, still an error
    putW(32'h0000_6000);
    addCopy(2, 3, 32'h0000_6100, 0);      // must never be written
    begin
      int keep;
      keep = expAddr.size() - 3;
      for (int i = 0; i < 3; i++) begin
        void'(expAddr.pop_back());
        void'(expData.pop_back());
        void'(expReq.pop_back());
      end
      check(expAddr.size() == keep, "R7", "scoreboard trim", 32'(expAddr.size()), 32'(keep));
    end
    pulseGo();
    waitEnd();
    check(bootError == 1'b1, "R7", "error raised", 32'(bootError), 32'h1);
    repeat (6) @(negedge clk);
    check(bootError == 1'b1, "R7", "error held", 32'(bootError), 32'h1);
    check(doneCount == 1, "R7", "no done on error", 32'(doneCount), 32'h1);
    check(expAddr.size() == 0, "R7", "writes before error", 32'(expAddr.size()), 32'h0);

    // ---- image 3: restart from error, localId = 1 ----
    clearRom();
    localId = 3'd1;
    addZero(1, 1, 32'h0000_0800);         // R4 single word
    addCopy(3, 0, 32'h0000_9300, 0);      // R5 skip with count 0
    addCopy(1, 1, 32'h0000_0900, 0);      // R3 single word
    addFinal(1, 0, 32'h0000_0000);        // R8
    pulseGo();
    check(bootError == 1'b0, "R1", "error cleared by start", 32'(bootError), 32'h0);
    waitEnd();
    repeat (3) @(negedge clk);
    check(doneCount == 2, "R9", "done pulses image 3", 32'(doneCount), 32'h2);
    check(bootDone == 1'b0, "R9", "idle after done", 32'(bootDone), 32'h0);
    check(expAddr.size() == 0, "R8", "writes left image 3", 32'(expAddr.size()), 32'h0);

    finishRun();
  end

endmodule